// File: doc/BRIEF.md
# Scoreboard Out-of-Order Issue Selector

This block is the issue stage of a multi-queue pipeline. It holds a small pre-issue queue that is kept in program order, entry 0 being the oldest. Each cycle it scans the valid entries from oldest to newest and picks up to three operations for dispatch. It picks at most one operation for each of three execution classes: memory, arithmetic and logical. An operation is picked only if its class queue downstream has room, if no hazard blocks it against in-flight or older waiting operations, and if the memory ordering rules allow it.

The picked entries leave the queue in the same cycle. The surviving entries move down to close the gaps and keep their relative order. Up to two newly fetched operations are appended behind them. A register scoreboard holds one busy bit for each architectural register. Issuing an operation that writes a register marks its destination busy. A writeback clear vector releases busy bits one cycle later.

The dispatch outputs are combinational. They are computed from the registered queue, the registered scoreboard and the occupancy inputs, which the downstream queues drive from their registered state.

Top module: `ooo_issue_sel`

## Requirements
- R1: While reset is active and in the first cycle after reset, the queue is empty (`pq_cnt` = 0, `pq_ops` all zero), `busy` is all zero, and no dispatch valid is high.
- R2: At each clock edge, the offered fetch lanes (`fe_vld`) are appended behind the surviving entries, lane 0 before lane 1. Only as many are accepted as there were free slots at the start of the cycle (DEPTH − `pq_cnt`). Offers beyond that are dropped.
- R3: An operation word is 27 bits: [4:0] second source, [9:5] first source, [14:10] destination, [15] second source used, [16] store flag, [18:17] class (0 memory, 1 arithmetic, 2 logical, 3 never issues), [26:19] tag. For each class, the oldest eligible entry of that class is presented on that class's dispatch port with its word unchanged. Eligible entries may bypass older blocked ones.
- R4: An operation is dispatched only when its class occupancy input is below the downstream depth: 2 for memory, 1 for arithmetic, 1 for logical.
- R5: An operation is not dispatched while any source it reads, or the destination it writes, has its busy bit set.
- R6: An operation is not dispatched if an older entry still in the queue writes a register that it reads (RAW) or writes the same destination (WAW).
- R7: An operation is not dispatched if it writes a register that an older entry still in the queue reads (WAR).
- R8: A memory operation is not dispatched while any older entry in the queue is a store. Loads do not hold back later memory operations.
- R9: Dispatched entries are removed at the clock edge. Survivors shift toward entry 0 in their original order, and unused slots read as zero.
- R10: Dispatching a writer marks its destination busy from the next cycle. A `wb_clr` bit clears its register from the next cycle. If a set and a clear hit the same register in one cycle, the set wins.
- R11: Register 0 is never busy and never causes a hazard. Stores write no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_vld | input | 2 | Fetch lane valids |
| fe_ops | input | 54 | Fetch lane words, lane 0 in the low 27 bits |
| mq_occ | input | 2 | Memory dispatch queue occupancy at cycle start |
| aq_occ | input | 1 | Arithmetic dispatch queue occupancy at cycle start |
| lq_occ | input | 1 | Logical dispatch queue occupancy at cycle start |
| wb_clr | input | 32 | Writeback busy-clear vector, one bit per register |
| mem_vld | output | 1 | Memory dispatch valid |
| mem_op | output | 27 | Memory dispatch word |
| ari_vld | output | 1 | Arithmetic dispatch valid |
| ari_op | output | 27 | Arithmetic dispatch word |
| log_vld | output | 1 | Logical dispatch valid |
| log_op | output | 27 | Logical dispatch word |
| pq_ops | output | 108 | Queue contents, entry 0 in the low 27 bits |
| pq_cnt | output | 3 | Number of valid queue entries |
| busy | output | 32 | Register busy vector |

## Verification
Directed sequences cover several situations. A queue that is filled and then overfilled separates the append limit from compaction. Opening one downstream class at a time shows that the class gate works on its own. A store followed by a load separates memory ordering from ordinary register hazards. RAW, WAR and busy-bit cases use the same registers, so the cause of each stall is known. A set and a clear that coincide, and operations on register 0, separate the scoreboard priority and the zero-register exemption. Random traffic then draws operands from six registers so that hazards are dense, with random occupancy and random clears, and compares every output each cycle against a reference model. This exposes wrong bypass choices and errors in compaction order.

// File: rtl/issue_pkg.sv
package issue_pkg;
  localparam int NREG = 32;
  localparam int RIDW = $clog2(NREG);
  localparam int TAGW = 8;
  localparam int NCLS = 3;

  typedef enum logic [1:0] {
    CL_MEM  = 2'd0,
    CL_ARI  = 2'd1,
    CL_LOG  = 2'd2,
    CL_NONE = 2'd3
  } cls_e;

  typedef struct packed {
    logic [TAGW-1:0] tag;
    cls_e            cls;
    logic            st;
    logic            use2;
    logic [RIDW-1:0] rd;
    logic [RIDW-1:0] rs1;
    logic [RIDW-1:0] rs2;
  } iss_op_t;

  localparam int OPW = $bits(iss_op_t);

  function automatic logic op_writes(iss_op_t o);
    return (o.rd != '0) && !((o.cls == CL_MEM) && o.st);
  endfunction

  function automatic logic op_reads(iss_op_t o, logic [RIDW-1:0] r);
    return (r != '0) && ((o.rs1 == r) || (o.use2 && (o.rs2 == r)));
  endfunction
endpackage

// File: rtl/issue_hazard.sv
module issue_hazard
  import issue_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IDX   = 0
) (
  input  iss_op_t [DEPTH-1:0] ops,
  input  logic    [DEPTH-1:0] vld,
  input  logic    [NREG-1:0]  busy,
  input  logic    [NCLS-1:0]  room,
  output logic                ok
);
  iss_op_t me;
  logic    blk;
  logic    has_room;
  logic    unused_bits;

  assign me          = ops[IDX];
  assign unused_bits = ^{ops, vld};

  always_comb begin
    case (me.cls)
      CL_MEM:  has_room = room[0];
      CL_ARI:  has_room = room[1];
      CL_LOG:  has_room = room[2];
      default: has_room = 1'b0;
    endcase
  end

  always_comb begin
    blk = 1'b0;
    if (op_writes(me) && busy[me.rd])              blk = 1'b1;
    if ((me.rs1 != '0) && busy[me.rs1])            blk = 1'b1;
    if (me.use2 && (me.rs2 != '0) && busy[me.rs2]) blk = 1'b1;
    for (int j = 0; j < IDX; j++) begin
      if (vld[j]) begin
        if (op_writes(ops[j]) && op_reads(me, ops[j].rd)) blk = 1'b1;
        if (op_writes(ops[j]) && op_writes(me) && (ops[j].rd == me.rd)) blk = 1'b1;
        if (op_writes(me) && op_reads(ops[j], me.rd)) blk = 1'b1;
        if ((me.cls == CL_MEM) && (ops[j].cls == CL_MEM) && ops[j].st) blk = 1'b1;
      end
    end
  end

  assign ok = vld[IDX] && !blk && has_room;
endmodule

// File: rtl/issue_pick.sv
module issue_pick
  import issue_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  iss_op_t [DEPTH-1:0]            ops,
  input  logic    [DEPTH-1:0]            ok,
  output logic    [NCLS-1:0][DEPTH-1:0]  sel
);
  logic [NCLS-1:0] found;

  always_comb begin
    sel   = '0;
    found = '0;
    for (int c = 0; c < NCLS; c++) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!found[c] && ok[i] && (ops[i].cls == cls_e'(c))) begin
          sel[c][i] = 1'b1;
          found[c]  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/issue_queue.sv
module issue_queue
  import issue_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int FW    = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic    [DEPTH-1:0]  issued,
  input  logic    [FW-1:0]     fe_vld,
  input  iss_op_t [FW-1:0]     fe_ops,
  output iss_op_t [DEPTH-1:0]  q_ops,
  output logic    [DEPTH-1:0]  q_vld,
  output logic    [CW-1:0]     q_cnt
);
  iss_op_t [DEPTH-1:0] n_ops;
  logic    [CW-1:0]    n_cnt;
  logic    [CW-1:0]    space;
  logic                q_en;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) q_vld[i] = (q_cnt > CW'(i));
  end

  assign q_en = (|(q_vld & issued)) || (|fe_vld);

  always_comb begin
    n_ops = '0;
    n_cnt = '0;
    space = CW'(DEPTH) - q_cnt;
    for (int i = 0; i < DEPTH; i++) begin
      if (q_vld[i] && !issued[i]) begin
        for (int s = 0; s < DEPTH; s++) if (n_cnt == CW'(s)) n_ops[s] = q_ops[i];
        n_cnt = n_cnt + 1'b1;
      end
    end
    for (int k = 0; k < FW; k++) begin
      if (fe_vld[k] && (space != '0)) begin
        for (int s = 0; s < DEPTH; s++) if (n_cnt == CW'(s)) n_ops[s] = fe_ops[k];
        n_cnt = n_cnt + 1'b1;
        space = space - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ops <= '0;
      q_cnt <= '0;
    end else if (q_en) begin
      q_ops <= n_ops;
      q_cnt <= n_cnt;
    end
  end

  // R2
  cnt_within_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CW'(DEPTH));

  // R9
  issue_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issued & ~q_vld) == '0);
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import issue_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] set_vec,
  input  logic [NREG-1:0] clr_vec,
  output logic [NREG-1:0] busy_q
);
  logic [NREG-1:0] busy_d;
  logic            sb_en;

  assign sb_en = (|set_vec) || (|clr_vec);

  always_comb begin
    busy_d    = (busy_q & ~clr_vec) | set_vec;
    busy_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_q <= '0;
    else if (sb_en) busy_q <= busy_d;
  end

  // R11
  zero_reg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q[0]);
endmodule

// File: rtl/ooo_issue_sel.sv
module ooo_issue_sel
  import issue_pkg::*;
#(
  parameter int  DEPTH = 4,
  parameter int  FW    = 2,
  parameter int  MQ_D  = 2,
  parameter int  AQ_D  = 1,
  parameter int  LQ_D  = 1,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int MOW   = $clog2(MQ_D + 1),
  localparam int AOW   = $clog2(AQ_D + 1),
  localparam int LOW   = $clog2(LQ_D + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [FW-1:0]          fe_vld,
  input  logic [FW*OPW-1:0]      fe_ops,
  input  logic [MOW-1:0]         mq_occ,
  input  logic [AOW-1:0]         aq_occ,
  input  logic [LOW-1:0]         lq_occ,
  input  logic [NREG-1:0]        wb_clr,
  output logic                   mem_vld,
  output logic [OPW-1:0]         mem_op,
  output logic                   ari_vld,
  output logic [OPW-1:0]         ari_op,
  output logic                   log_vld,
  output logic [OPW-1:0]         log_op,
  output logic [DEPTH*OPW-1:0]   pq_ops,
  output logic [CW-1:0]          pq_cnt,
  output logic [NREG-1:0]        busy
);
  iss_op_t [FW-1:0]              fe_arr;
  iss_op_t [DEPTH-1:0]           q_ops;
  logic    [DEPTH-1:0]           q_vld;
  logic    [CW-1:0]              q_cnt;
  logic    [NREG-1:0]            busy_q;
  logic    [NCLS-1:0]            room;
  logic    [DEPTH-1:0]           elig;
  logic    [NCLS-1:0][DEPTH-1:0] sel;
  logic    [DEPTH-1:0]           issued;
  logic    [NCLS-1:0]            disp_vld;
  iss_op_t [NCLS-1:0]            disp_op;
  logic    [NREG-1:0]            set_vec;

  assign fe_arr  = fe_ops;
  assign room[0] = mq_occ < MOW'(MQ_D);
  assign room[1] = aq_occ < AOW'(AQ_D);
  assign room[2] = lq_occ < LOW'(LQ_D);

  issue_queue #(.DEPTH(DEPTH), .FW(FW)) u_queue (
    .clk    (clk),
    .rst_n  (rst_n),
    .issued (issued),
    .fe_vld (fe_vld),
    .fe_ops (fe_arr),
    .q_ops  (q_ops),
    .q_vld  (q_vld),
    .q_cnt  (q_cnt)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_hz
    issue_hazard #(.DEPTH(DEPTH), .IDX(g)) u_hz (
      .ops  (q_ops),
      .vld  (q_vld),
      .busy (busy_q),
      .room (room),
      .ok   (elig[g])
    );
  end

  issue_pick #(.DEPTH(DEPTH)) u_pick (
    .ops (q_ops),
    .ok  (elig),
    .sel (sel)
  );

  always_comb begin
    issued   = '0;
    disp_vld = '0;
    disp_op  = '0;
    set_vec  = '0;
    for (int c = 0; c < NCLS; c++) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (sel[c][i]) begin
          disp_vld[c] = 1'b1;
          disp_op[c]  = q_ops[i];
          issued[i]   = 1'b1;
        end
      end
      if (disp_vld[c] && op_writes(disp_op[c])) set_vec[disp_op[c].rd] = 1'b1;
    end
  end

  issue_scoreboard u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (wb_clr),
    .busy_q  (busy_q)
  );

  assign mem_vld = disp_vld[0];
  assign mem_op  = disp_op[0];
  assign ari_vld = disp_vld[1];
  assign ari_op  = disp_op[1];
  assign log_vld = disp_vld[2];
  assign log_op  = disp_op[2];
  assign pq_ops  = q_ops;
  assign pq_cnt  = q_cnt;
  assign busy    = busy_q;

  // R4
  mem_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_vld[0] |-> (mq_occ < MOW'(MQ_D)));

  // R5
  ari_dest_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_vld[1] |-> !busy_q[disp_op[1].rd]);

  // R10
  ari_dest_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_vld[1] && (disp_op[1].rd != '0)) |=> busy_q[$past(disp_op[1].rd)]);

  // R10
  log_dest_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_vld[2] && (disp_op[2].rd != '0)) |=> busy_q[$past(disp_op[2].rd)]);
endmodule

// File: tb/ooo_issue_sel_bench.sv
`timescale 1ns/1ps
module ooo_issue_sel_bench;
  localparam int OPW   = 27;
  localparam int DEPTH = 4;
  localparam int TCLK  = 20;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [1:0]           fe_vld;
  logic [2*OPW-1:0]     fe_ops;
  logic [1:0]           mq_occ;
  logic                 aq_occ, lq_occ;
  logic [31:0]          wb_clr;
  logic                 mem_vld, ari_vld, log_vld;
  logic [OPW-1:0]       mem_op, ari_op, log_op;
  logic [DEPTH*OPW-1:0] pq_ops;
  logic [2:0]           pq_cnt;
  logic [31:0]          busy;

  int n_chk = 0;
  int n_fail = 0;

  logic [OPW-1:0] m_q [DEPTH];
  int             m_cnt;
  logic [31:0]    m_busy;
  logic [2:0]     e_v;
  logic [OPW-1:0] e_op [3];
  logic [DEPTH-1:0] e_iss;

  always #(TCLK/2) clk = ~clk;

  ooo_issue_sel u_ooo_issue_sel (
    .clk(clk), .rst_n(rst_n), .fe_vld(fe_vld), .fe_ops(fe_ops),
    .mq_occ(mq_occ), .aq_occ(aq_occ), .lq_occ(lq_occ), .wb_clr(wb_clr),
    .mem_vld(mem_vld), .mem_op(mem_op), .ari_vld(ari_vld), .ari_op(ari_op),
    .log_vld(log_vld), .log_op(log_op), .pq_ops(pq_ops), .pq_cnt(pq_cnt),
    .busy(busy)
  );

  function automatic logic [OPW-1:0] mk(int tag, int cls, bit st, bit u2, int rd, int rs1, int rs2);
    return {tag[7:0], cls[1:0], st, u2, rd[4:0], rs1[4:0], rs2[4:0]};
  endfunction

  function automatic bit wr(logic [OPW-1:0] o);
    return (o[14:10] != 5'd0) && !((o[18:17] == 2'd0) && o[16]);
  endfunction

  function automatic bit rdx(logic [OPW-1:0] o, logic [4:0] r);
    return (r != 5'd0) && ((o[9:5] == r) || (o[15] && (o[4:0] == r)));
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(bit good, string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic calc();
    logic [OPW-1:0] o, p;
    int  c;
    bit  ok;
    e_v   = '0;
    e_iss = '0;
    for (int k = 0; k < 3; k++) e_op[k] = '0;
    for (int i = 0; i < m_cnt; i++) begin
      o  = m_q[i];
      c  = int'(o[18:17]);
      ok = 1'b1;
      case (c)
        0:       ok = (mq_occ < 2'd2);
        1:       ok = (aq_occ == 1'b0);
        2:       ok = (lq_occ == 1'b0);
        default: ok = 1'b0;
      endcase
      if (wr(o) && m_busy[o[14:10]]) ok = 1'b0;
      if ((o[9:5] != 0) && m_busy[o[9:5]]) ok = 1'b0;
      if (o[15] && (o[4:0] != 0) && m_busy[o[4:0]]) ok = 1'b0;
      for (int j = 0; j < i; j++) begin
        p = m_q[j];
        if (wr(p) && rdx(o, p[14:10])) ok = 1'b0;
        if (wr(p) && wr(o) && (p[14:10] == o[14:10])) ok = 1'b0;
        if (wr(o) && rdx(p, o[14:10])) ok = 1'b0;
        if ((c == 0) && (p[18:17] == 2'd0) && p[16]) ok = 1'b0;
      end
      if (ok && (c < 3) && !e_v[c]) begin
        e_v[c]   = 1'b1;
        e_op[c]  = o;
        e_iss[i] = 1'b1;
      end
    end
  endtask

  task automatic compare(string tag);
    logic [DEPTH*OPW-1:0] eq;
    eq = '0;
    for (int i = 0; i < m_cnt; i++) eq[i*OPW +: OPW] = m_q[i];
    chk((pq_ops == eq) && (pq_cnt == 3'(m_cnt)), {tag, " queue"}, {pq_cnt, pq_ops}, {3'(m_cnt), eq});
    chk({mem_vld, mem_op} == {e_v[0], e_op[0]}, {tag, " mem port"}, {mem_vld, mem_op}, {e_v[0], e_op[0]});
    chk({ari_vld, ari_op} == {e_v[1], e_op[1]}, {tag, " ari port"}, {ari_vld, ari_op}, {e_v[1], e_op[1]});
    chk({log_vld, log_op} == {e_v[2], e_op[2]}, {tag, " log port"}, {log_vld, log_op}, {e_v[2], e_op[2]});
    chk(busy == m_busy, {tag, " busy"}, busy, m_busy);
  endtask

  task automatic advance();
    logic [OPW-1:0] nq [DEPTH];
    logic [31:0]    setv;
    int n, free;
    n = 0;
    free = DEPTH - m_cnt;
    for (int i = 0; i < DEPTH; i++) nq[i] = '0;
    for (int i = 0; i < m_cnt; i++) if (!e_iss[i]) begin nq[n] = m_q[i]; n++; end
    for (int k = 0; k < 2; k++)
      if (fe_vld[k] && (free > 0)) begin nq[n] = fe_ops[k*OPW +: OPW]; n++; free--; end
    for (int i = 0; i < DEPTH; i++) m_q[i] = nq[i];
    m_cnt = n;
    setv = '0;
    for (int c = 0; c < 3; c++) if (e_v[c] && wr(e_op[c])) setv[e_op[c][14:10]] = 1'b1;
    m_busy = (m_busy & ~wb_clr) | setv;
    m_busy[0] = 1'b0;
  endtask

  task automatic cyc(logic [1:0] fv, logic [OPW-1:0] f0, logic [OPW-1:0] f1,
                     logic [1:0] mo, logic ao, logic lo, logic [31:0] clr, string tag);
    @(negedge clk);
    fe_vld = fv; fe_ops = {f1, f0};
    mq_occ = mo; aq_occ = ao; lq_occ = lo; wb_clr = clr;
    #1;
    calc();
    compare(tag);
    advance();
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) cyc(2'b00, '0, '0, 2'd0, 1'b0, 1'b0, '1, "R9");
  endtask

  initial begin
    #(TCLK * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hang expected completion");
    report();
  end

  initial begin
    logic [OPW-1:0] o0, o1;
    int cl, seed;
    seed = $urandom(32'h5eed_1234);
    rst_n = 1'b0; fe_vld = '0; fe_ops = '0; mq_occ = '0; aq_occ = 1'b0; lq_occ = 1'b0; wb_clr = '0;
    for (int i = 0; i < DEPTH; i++) m_q[i] = '0;
    m_cnt = 0; m_busy = '0;
    repeat (3) @(negedge clk);
    chk((pq_cnt == 0) && (busy == 0) && !mem_vld && !ari_vld && !log_vld, "R1 in reset",
        {pq_cnt, busy, mem_vld, ari_vld, log_vld}, '0);
    rst_n = 1'b1;
    #1;
    chk((pq_cnt == 0) && (pq_ops == 0) && (busy == 0), "R1 after release", {pq_cnt, busy}, '0);

    // R2 fill, then overfill with every class blocked
    cyc(2'b11, mk(1,1,0,1,1,2,3), mk(2,2,0,0,4,5,0), 2'd2, 1'b1, 1'b1, '0, "R2");
    cyc(2'b11, mk(3,0,1,1,0,6,7), mk(4,0,0,0,8,9,0), 2'd2, 1'b1, 1'b1, '0, "R2");
    cyc(2'b11, mk(5,1,0,0,10,0,0), mk(6,2,0,0,11,0,0), 2'd2, 1'b1, 1'b1, '0, "R2");
    cyc(2'b00, '0, '0, 2'd2, 1'b1, 1'b1, '0, "R2");
    chk(pq_cnt == 3'd4, "R2 count", pq_cnt, 3'd4);
    chk(pq_ops[OPW-1:OPW-8] == 8'd1, "R2 oldest", pq_ops[OPW-1:OPW-8], 8'd1);
    // R4 only the arithmetic class open
    cyc(2'b00, '0, '0, 2'd2, 1'b0, 1'b1, '0, "R4");
    chk(ari_vld && (ari_op[26:19] == 8'd1) && !log_vld && !mem_vld, "R4 single class",
        {ari_vld, log_vld, mem_vld}, 3'b100);
    // R8 store ahead of load
    cyc(2'b00, '0, '0, 2'd0, 1'b0, 1'b0, '0, "R8");
    chk(pq_ops[OPW-1:OPW-8] == 8'd2, "R9 compacted head", pq_ops[OPW-1:OPW-8], 8'd2);
    chk(mem_vld && (mem_op[26:19] == 8'd3), "R8 store first", mem_op[26:19], 8'd3);
    cyc(2'b00, '0, '0, 2'd0, 1'b0, 1'b0, '0, "R8");
    chk(mem_vld && (mem_op[26:19] == 8'd4), "R8 load after store", mem_op[26:19], 8'd4);
    drain();

    // R6 RAW on older entry, R10 set beats clear, R5 busy stall
    cyc(2'b11, mk(10,1,0,1,3,1,2), mk(11,2,0,0,5,3,0), 2'd2, 1'b1, 1'b1, '0, "R6");
    cyc(2'b00, '0, '0, 2'd0, 1'b0, 1'b0, 32'h8, "R6");
    chk(ari_vld && !log_vld, "R6 reader held", {ari_vld, log_vld}, 2'b10);
    cyc(2'b00, '0, '0, 2'd0, 1'b0, 1'b0, '0, "R10");
    chk(busy[3] == 1'b1, "R10 set wins", busy[3], 1'b1);
    chk(!log_vld, "R5 busy source", log_vld, 1'b0);
    cyc(2'b00, '0, '0, 2'd0, 1'b0, 1'b0, 32'h8, "R10");
    chk(!log_vld, "R10 clear delayed", log_vld, 1'b0);
    cyc(2'b00, '0, '0, 2'd0, 1'b0, 1'b0, '0, "R5");
    chk(log_vld && (log_op[26:19] == 8'd11), "R5 released", log_op[26:19], 8'd11);
    drain();

    // R7 younger writer of a register an older entry reads
    cyc(2'b11, mk(20,2,0,1,6,2,7), mk(21,1,0,0,7,1,0), 2'd2, 1'b1, 1'b1, '0, "R7");
    cyc(2'b00, '0, '0, 2'd2, 1'b0, 1'b1, '0, "R7");
    chk(!ari_vld, "R7 WAR stall", ari_vld, 1'b0);
    drain();

    // R11 register zero
    cyc(2'b11, mk(30,1,0,1,0,0,0), mk(31,2,0,0,9,0,0), 2'd0, 1'b0, 1'b0, '0, "R11");
    cyc(2'b00, '0, '0, 2'd0, 1'b0, 1'b0, '0, "R11");
    chk(ari_vld && log_vld, "R11 no hazard on zero", {ari_vld, log_vld}, 2'b11);
    cyc(2'b00, '0, '0, 2'd0, 1'b0, 1'b0, '0, "R11");
    chk((busy[0] == 1'b0) && (busy[9] == 1'b1), "R11 zero never busy", busy[9:0], 10'h200);
    drain();

    // R3 random traffic with dense register reuse
    for (int t = 0; t < 3000; t++) begin
      cl = int'($urandom % 3);
      o0 = mk(int'($urandom), cl, (cl == 0) && $urandom[0], $urandom[0],
              int'($urandom % 6), int'($urandom % 6), int'($urandom % 6));
      cl = int'($urandom % 3);
      o1 = mk(int'($urandom), cl, (cl == 0) && $urandom[0], $urandom[0],
              int'($urandom % 6), int'($urandom % 6), int'($urandom % 6));
      cyc(2'($urandom), o0, o1, 2'($urandom % 3), ($urandom % 3) == 0, ($urandom % 3) == 0,
          m_busy & $urandom, "R3");
    end
    report();
  end
endmodule